// File: doc/BRIEF.md
# Edge-Interrupt GPIO Port

This block is a 32-pin general-purpose I/O port behind a simple 32-bit register bus with a single-cycle write strobe and a combinational read path. Software sets each pin as an input or an output, and each output as push-pull or open-drain. It can read the pin levels and drive output values. Input levels pass through a two-flop synchroniser before software or the edge logic sees them.

Each pin has an edge detector that compares the synchronised level with its value one cycle earlier. A per-pin sense bit selects the edges that count: falling edges only, or both rising and falling. Each edge that counts sets a sticky event bit, and software clears event bits by writing ones to them. One interrupt line is high while any event bit is pending whose mask bit is set.

Every register uses the same bit order: pin n lives in register bit 31−n, so pin 0 is the most significant bit. The pad side uses plain vectors indexed by pin number: pin_out, pin_oe and pin_in.

Top module: `gpio_edge_port`

## Requirements
- R1: After synchronous reset, every register reads zero, pin_oe is all zero (all pins are inputs) and irq_out is low.
- R2: Register bit 31−n belongs to pin n. Byte offsets are: direction 0x00, open-drain 0x04, data 0x08, event 0x0C, mask 0x10 and edge sense 0x14. A direction bit of 1 makes the pin an output, so pin_oe[n] goes high.
- R3: A push-pull output pin (open-drain bit 0) drives pin_out[n] with its data latch bit and holds pin_oe[n] high.
- R4: An open-drain output pin (open-drain bit 1) with data 0 drives low (pin_oe[n]=1, pin_out[n]=0). With data 1 it releases the pad (pin_oe[n]=0).
- R5: A read of the data register returns the latch value for output pins and the synchronised level for input pins. A change on pin_in first shows in the read after the second rising clock edge.
- R6: With an edge-sense bit of 0, both rising and falling synchronised edges set that pin's event bit. The bit reads as set after the third rising clock edge that follows the pin change, and not before.
- R7: With an edge-sense bit of 1, only falling edges set the event bit, and rising edges leave it clear.
- R8: A write to the event register clears each bit written as 1 and leaves each bit written as 0 unchanged. Writing 0xFFFFFFFF clears every pending event.
- R9: If a new edge and a clearing write hit the same event bit in the same cycle, the bit stays set.
- R10: irq_out is high exactly when the event register AND the mask register is non-zero. A mask bit of 1 enables its pin.
- R11: Reads of unmapped or misaligned offsets (0x18, 0x1C, any offset with its low two bits non-zero) return zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe; the write takes effect at the rising edge |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pin_in | input | 32 | Pad input levels, indexed by pin number |
| pin_out | output | 32 | Pad output values, indexed by pin number |
| pin_oe | output | 32 | Pad output enables, indexed by pin number |
| irq_out | output | 1 | Interrupt: pending and enabled event present |

## Verification
The event register is the one place where two functions can act in the same cycle. A synchronised edge can set a bit while a bus write of ones clears it. To provoke this, the bench raises a pin at a falling clock edge and counts two rising edges. It then holds a clear-all write for the third edge, which is the same edge at which the detected change is captured. The case passes only if that pin's event bit still reads as set afterwards. A second clear-all write, with no edge arriving, must then leave the register at zero.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

    localparam int PIN_COUNT = 32;
    localparam int ADDR_W    = 5;

    typedef logic [PIN_COUNT-1:0] word_t;

    typedef enum logic [2:0] {
        SEL_DIR   = 3'd0,
        SEL_ODR   = 3'd1,
        SEL_DATA  = 3'd2,
        SEL_EVENT = 3'd3,
        SEL_MASK  = 3'd4,
        SEL_SENSE = 3'd5,
        SEL_NONE  = 3'd7
    } reg_sel_e;

    // Configuration registers, held in bus bit order (pin n at bit 31-n).
    typedef struct packed {
        word_t dir;
        word_t odr;
        word_t data;
        word_t mask;
        word_t sense;
    } cfg_t;

    // Word-aligned offsets 0x00..0x14 map to registers; everything else is void.
    function automatic reg_sel_e decode_offset(input logic [ADDR_W-1:0] addr);
        reg_sel_e sel;
        if (addr[1:0] != 2'b00) begin
            sel = SEL_NONE;
        end else begin
            case (int'(addr[ADDR_W-1:2]))
                0:       sel = SEL_DIR;
                1:       sel = SEL_ODR;
                2:       sel = SEL_DATA;
                3:       sel = SEL_EVENT;
                4:       sel = SEL_MASK;
                5:       sel = SEL_SENSE;
                default: sel = SEL_NONE;
            endcase
        end
        return sel;
    endfunction

    // Bus bit order <-> pin order: bit (PIN_COUNT-1-n) <-> pin n.
    function automatic word_t flip_order(input word_t w);
        word_t r;
        for (int i = 0; i < PIN_COUNT; i++) begin
            r[i] = w[PIN_COUNT-1-i];
        end
        return r;
    endfunction

endpackage

// File: rtl/gpio_sync_chain.sv
module gpio_sync_chain #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= '0;
                else     chain[s] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= '0;
                else     chain[s] <= chain[s-1];
            end
        end
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/gpio_edge_detect.sv
module gpio_edge_detect #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] level,
    input  logic [WIDTH-1:0] fall_only,
    output logic [WIDTH-1:0] hit
);
    logic [WIDTH-1:0] prev_q;
    logic [WIDTH-1:0] rise;
    logic [WIDTH-1:0] fall;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= level;
    end

    always_comb begin
        rise = level & ~prev_q;
        fall = ~level & prev_q;
        hit  = fall | (rise & ~fall_only);
    end
endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] is_out,
    input  logic [WIDTH-1:0] is_od,
    input  logic [WIDTH-1:0] value,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_oe
);
    for (genvar p = 0; p < WIDTH; p++) begin : g_pin
        always_comb begin
            if (!is_out[p]) begin
                pad_oe[p]  = 1'b0;
                pad_out[p] = 1'b0;
            end else if (is_od[p]) begin
                // open drain: pull low on 0, float on 1
                pad_oe[p]  = ~value[p];
                pad_out[p] = 1'b0;
            end else begin
                pad_oe[p]  = 1'b1;
                pad_out[p] = value[p];
            end
        end
    end
endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
    import gpio_edge_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [31:0]       pin_in,
    output logic [31:0]       pin_out,
    output logic [31:0]       pin_oe,
    output logic              irq_out
);
    cfg_t     cfg_q;
    word_t    ev_q;
    word_t    ev_d;
    word_t    clr_bits;
    reg_sel_e sel;

    word_t dir_pins, od_pins, data_pins, sense_pins;
    word_t level_pins, level_bits;
    word_t hit_pins, set_bits;

    assign sel = decode_offset(bus_addr);

    // Pin-order views of the configuration.
    assign dir_pins   = flip_order(cfg_q.dir);
    assign od_pins    = flip_order(cfg_q.odr);
    assign data_pins  = flip_order(cfg_q.data);
    assign sense_pins = flip_order(cfg_q.sense);

    gpio_sync_chain #(.WIDTH(PIN_COUNT), .STAGES(SYNC_STAGES)) i_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (pin_in),
        .dout (level_pins)
    );

    gpio_edge_detect #(.WIDTH(PIN_COUNT)) i_edge (
        .clk       (clk),
        .rst       (rst),
        .level     (level_pins),
        .fall_only (sense_pins),
        .hit       (hit_pins)
    );

    gpio_pad_drive #(.WIDTH(PIN_COUNT)) i_pad (
        .is_out  (dir_pins),
        .is_od   (od_pins),
        .value   (data_pins),
        .pad_out (pin_out),
        .pad_oe  (pin_oe)
    );

    assign level_bits = flip_order(level_pins);
    assign set_bits   = flip_order(hit_pins);

    // Configuration registers.
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (bus_wr) begin
            case (sel)
                SEL_DIR:   cfg_q.dir   <= bus_wdata;
                SEL_ODR:   cfg_q.odr   <= bus_wdata;
                SEL_DATA:  cfg_q.data  <= bus_wdata;
                SEL_MASK:  cfg_q.mask  <= bus_wdata;
                SEL_SENSE: cfg_q.sense <= bus_wdata;
                default:   ;
            endcase
        end
    end

    // Sticky events: ones written clear, a fresh edge overrides the clear.
    always_comb begin
        clr_bits = (bus_wr && sel == SEL_EVENT) ? bus_wdata : '0;
        ev_d     = (ev_q & ~clr_bits) | set_bits;
    end

    always_ff @(posedge clk) begin
        if (rst) ev_q <= '0;
        else     ev_q <= ev_d;
    end

    always_comb begin
        case (sel)
            SEL_DIR:   bus_rdata = cfg_q.dir;
            SEL_ODR:   bus_rdata = cfg_q.odr;
            SEL_DATA:  bus_rdata = (cfg_q.data & cfg_q.dir) | (level_bits & ~cfg_q.dir);
            SEL_EVENT: bus_rdata = ev_q;
            SEL_MASK:  bus_rdata = cfg_q.mask;
            SEL_SENSE: bus_rdata = cfg_q.sense;
            default:   bus_rdata = '0;
        endcase
    end

    assign irq_out = |(ev_q & cfg_q.mask);

endmodule

// File: rtl/gpio_edge_port_checker.sv
module gpio_edge_port_checker (
    input logic        clk,
    input logic        rst,
    input logic        bus_wr,
    input logic [4:0]  bus_addr,
    input logic [31:0] bus_wdata,
    input logic [31:0] pin_out,
    input logic [31:0] pin_oe,
    input logic        irq_out,
    input logic [31:0] ev_q,
    input logic [31:0] mask_bits,
    input logic [31:0] set_bits,
    input logic [31:0] dir_pins,
    input logic [31:0] od_pins
);
    logic rst_prev = 1'b0;

    always_ff @(posedge clk) rst_prev <= rst;

    // R1: the cycle after reset, outputs are idle and no event is pending
    always @(posedge clk) begin
        if (rst_prev && !rst) begin
            assert_reset_idle_R1: assert (pin_oe == '0 && !irq_out && ev_q == '0)
                else $error("reset state wrong");
        end
    end

    // R2: only pins configured as outputs may enable their pad
    assert_oe_only_outputs_R2: assert property (@(posedge clk) disable iff (rst)
        (pin_oe & ~dir_pins) == '0);

    // R4: an open-drain pad never drives high
    assert_od_never_high_R4: assert property (@(posedge clk) disable iff (rst)
        (pin_out & pin_oe & od_pins) == '0);

    // R6: event bits only appear where the edge logic reported a hit
    assert_event_needs_edge_R6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((ev_q & ~$past(ev_q) & ~$past(set_bits)) == '0));

    // R8: clear-all with no new edge empties the register
    assert_clear_all_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 5'h0C && bus_wdata == 32'hFFFF_FFFF && set_bits == '0)
        |=> ev_q == '0);

    // R9: a hit is always captured, whatever the bus does
    assert_edge_wins_R9: assert property (@(posedge clk) disable iff (rst)
        (set_bits != '0) |=> ((ev_q & $past(set_bits)) == $past(set_bits)));

    // R10: nothing masked in means no interrupt
    assert_irq_needs_mask_R10: assert property (@(posedge clk) disable iff (rst)
        (mask_bits == '0) |-> !irq_out);
endmodule

bind gpio_edge_port gpio_edge_port_checker i_checker (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .irq_out   (irq_out),
    .ev_q      (ev_q),
    .mask_bits (cfg_q.mask),
    .set_bits  (set_bits),
    .dir_pins  (dir_pins),
    .od_pins   (od_pins)
);

// File: tb/test_gpio_edge_port.sv
module test_gpio_edge_port;
    localparam int CLK_PERIOD = 10;

    localparam logic [4:0] A_DIR = 5'h00, A_ODR = 5'h04, A_DATA = 5'h08,
                           A_EV = 5'h0C, A_MASK = 5'h10, A_SENSE = 5'h14;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out, pin_oe;
    logic        irq_out;

    int tests_run = 0;
    int tests_failed = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_edge_port i_gpio_edge_port (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests_run++;
        if (act !== exp) begin
            tests_failed++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
            $finish;
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic drive_pins(input logic [31:0] v);
        @(negedge clk);
        pin_in = v;
    endtask

    task automatic settle_and_clear();
        repeat (4) @(negedge clk);
        bus_write(A_EV, 32'hFFFF_FFFF);
    endtask

    task automatic t_reset();
        logic [31:0] r;
        bus_read(A_DIR, r);   check("R1 dir", r, 0);
        bus_read(A_ODR, r);   check("R1 odr", r, 0);
        bus_read(A_DATA, r);  check("R1 data", r, 0);
        bus_read(A_EV, r);    check("R1 event", r, 0);
        bus_read(A_MASK, r);  check("R1 mask", r, 0);
        bus_read(A_SENSE, r); check("R1 sense", r, 0);
        check("R1 pin_oe", pin_oe, 0);
        check("R1 irq", {31'b0, irq_out}, 0);
    endtask

    task automatic t_push_pull();
        logic [31:0] r;
        bus_write(A_DIR, 32'hC000_0000);   // pins 0,1 outputs
        bus_write(A_DATA, 32'h8000_0000);  // pin0=1, pin1=0
        check("R2 pin_oe order", pin_oe, 32'h0000_0003);
        check("R3 pin_out", pin_out, 32'h0000_0001);
        bus_read(A_DATA, r);
        check("R5 data read outputs", r, 32'h8000_0000);
    endtask

    task automatic t_open_drain();
        bus_write(A_ODR, 32'hC000_0000);
        check("R4 od oe", pin_oe, 32'h0000_0002);
        check("R4 od out low", pin_out & 32'h3, 32'h0);
        bus_write(A_DATA, 32'h4000_0000);  // pin0=0, pin1=1
        check("R4 od swap oe", pin_oe, 32'h0000_0001);
        bus_write(A_ODR, 0);
        bus_write(A_DIR, 0);
        check("R2 inputs no oe", pin_oe, 0);
    endtask

    task automatic t_input_read();
        logic [31:0] r;
        drive_pins(32'h0000_0005);         // pins 0,2 -> bits 31,29
        @(negedge clk);
        bus_read(A_DATA, r); check("R5 not yet after one edge", r, 0);
        @(negedge clk);
        bus_read(A_DATA, r); check("R5 level after two edges", r, 32'hA000_0000);
        drive_pins(0);
        settle_and_clear();
    endtask

    task automatic t_both_edges();
        logic [31:0] r;
        drive_pins(32'h0000_0010);         // pin 4 rises -> bit 27
        repeat (2) @(negedge clk);
        bus_read(A_EV, r); check("R6 not before third edge", r, 0);
        @(negedge clk);
        bus_read(A_EV, r); check("R6 rise sets event", r, 32'h0800_0000);
        bus_write(A_EV, 32'h0800_0000);
        drive_pins(0);
        repeat (3) @(negedge clk);
        bus_read(A_EV, r); check("R6 fall sets event", r, 32'h0800_0000);
        bus_write(A_EV, 32'hFFFF_FFFF);
    endtask

    task automatic t_falling_only();
        logic [31:0] r;
        bus_write(A_SENSE, 32'h0800_0000);
        drive_pins(32'h0000_0010);
        repeat (4) @(negedge clk);
        bus_read(A_EV, r); check("R7 rise ignored", r, 0);
        drive_pins(0);
        repeat (3) @(negedge clk);
        bus_read(A_EV, r); check("R7 fall sets event", r, 32'h0800_0000);
        bus_write(A_SENSE, 0);
        bus_write(A_EV, 32'hFFFF_FFFF);
    endtask

    task automatic t_w1c();
        logic [31:0] r;
        drive_pins(32'h0000_0030);         // pins 4,5
        drive_pins(0);
        repeat (4) @(negedge clk);
        bus_read(A_EV, r); check("R8 two pending", r, 32'h0C00_0000);
        bus_write(A_EV, 32'h0800_0000);
        bus_read(A_EV, r); check("R8 selective clear", r, 32'h0400_0000);
        bus_write(A_EV, 0);
        bus_read(A_EV, r); check("R8 zero write keeps", r, 32'h0400_0000);
    endtask

    task automatic t_irq();
        logic [31:0] r;
        check("R10 masked off", {31'b0, irq_out}, 0);
        bus_write(A_MASK, 32'h0400_0000);
        check("R10 enabled", {31'b0, irq_out}, 1);
        bus_write(A_MASK, 32'h0800_0000);
        check("R10 other pin", {31'b0, irq_out}, 0);
        bus_write(A_MASK, 32'h0400_0000);
        bus_write(A_EV, 32'hFFFF_FFFF);
        bus_read(A_EV, r); check("R8 clear all", r, 0);
        check("R10 cleared", {31'b0, irq_out}, 0);
        bus_write(A_MASK, 0);
    endtask

    task automatic t_collision();
        logic [31:0] r;
        drive_pins(32'h0000_0040);         // pin 6 -> bit 25
        settle_and_clear();
        drive_pins(0);
        repeat (4) @(negedge clk);
        bus_read(A_EV, r); check("R9 pre-set", r, 32'h0200_0000);
        drive_pins(32'h0000_0040);         // rise; captured at third edge
        repeat (2) @(negedge clk);
        bus_wr = 1'b1; bus_addr = A_EV; bus_wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        bus_wr = 1'b0;
        bus_read(A_EV, r); check("R9 edge beats clear", r, 32'h0200_0000);
        bus_write(A_EV, 32'hFFFF_FFFF);
        bus_read(A_EV, r); check("R9 later clear works", r, 0);
        drive_pins(0);
        settle_and_clear();
    endtask

    task automatic t_unmapped();
        logic [31:0] r;
        bus_write(A_DIR, 32'h1234_5678);
        bus_write(5'h18, 32'hFFFF_FFFF);
        bus_write(5'h1C, 32'hFFFF_FFFF);
        bus_write(5'h01, 32'hFFFF_FFFF);
        bus_read(5'h18, r); check("R11 read 0x18", r, 0);
        bus_read(5'h1C, r); check("R11 read 0x1C", r, 0);
        bus_read(5'h02, r); check("R11 misaligned read", r, 0);
        bus_read(A_DIR, r);   check("R11 dir kept", r, 32'h1234_5678);
        bus_read(A_ODR, r);   check("R11 odr kept", r, 0);
        bus_read(A_MASK, r);  check("R11 mask kept", r, 0);
        bus_read(A_SENSE, r); check("R11 sense kept", r, 0);
        bus_read(A_EV, r);    check("R11 event kept", r, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_push_pull();
        t_open_drain();
        t_input_read();
        t_both_edges();
        t_falling_only();
        t_w1c();
        t_irq();
        t_collision();
        t_unmapped();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        tests_run++;
        tests_failed++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule